// File: doc/BRIEF.md
# MII Carrier and Collision Signal Generator

This block drives the carrier-sense and collision outputs of a 10/100 media-independent interface from the transceiver's internal view of transmit activity and received carrier. Carrier sense covers the receive side alone when the port runs full duplex or acts as a repeater. Otherwise it covers traffic in either direction. Collision is raised while both directions are busy in half duplex.

Two optional behaviours share the collision output. A self-test mode lets the MAC see a synthetic collision that follows its own transmit enable. At 10 Mb/s a short signal-quality heartbeat pulse follows each frame, after a fixed delay. All timing is counted in single-cycle bit-time ticks that the surrounding logic supplies for the current speed. Each control bit arrives as a plain input.

Top module: `mii_crs_col_gen`

## Requirements
- R1: `crs` equals `rx_crs OR (tx_en AND NOT full_duplex AND NOT repeater)`, combinationally, in every cycle.
- R2: With `full_duplex` low, `col` is high in every cycle where `tx_en` and `rx_crs` are both high. With `col_test` low and no heartbeat in progress, `tx_en` alone or `rx_crs` alone leaves `col` low.
- R3: `col` is low in every cycle where `full_duplex` is high, whatever its source would be.
- R4: With `col_test` high, `col` is still low after the first `bit_tick` counted from the rise of `tx_en`. It is high after the second such tick, and it stays high while `tx_en` stays high.
- R5: With `col_test` high, after `tx_en` falls, `col` stays high until the first `bit_tick` and is low after it.
- R6: With `speed_10` high and `hb_disable` low, a fall of `tx_en` arms a heartbeat. A tick in the same clock as the fall is not counted. `col` is low after the 1st to 19th following ticks, high after the 20th to 29th, and low again after the 30th.
- R7: While `hb_disable` is high, no heartbeat is armed and any pending or running heartbeat is dropped, so `col` shows no pulse.
- R8: A rise of `tx_en` while a heartbeat is pending or running cancels it.
- R9: With `speed_10` low, a fall of `tx_en` produces no heartbeat.
- R10: During and right after reset, with all inputs low, `crs` and `col` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit activity |
| rx_crs | input | 1 | Receive carrier present |
| full_duplex | input | 1 | Full-duplex mode |
| repeater | input | 1 | Repeater mode |
| speed_10 | input | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s |
| col_test | input | 1 | Collision self-test enable |
| hb_disable | input | 1 | Suppress the heartbeat pulse |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
The combinational core is swept over all sixteen combinations of transmit, receive, duplex and repeater bits. That sweep separates the carrier OR from the collision AND, and it shows where each mode gate applies. The timed paths are walked one tick at a time, with the output checked after every tick. This locates the exact tick on which the test collision rises and clears, and the edges of the heartbeat window. Heartbeats are then tried in four other settings: interrupted by a new frame, disabled, at the fast speed, and in full duplex. Each of these must give a flat collision output.

// File: rtl/mii_crs_col_pkg.sv
package mii_crs_col_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;

  // True when a counter that starts at zero is on its final tick of a span of len ticks.
  function automatic logic span_done(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

endpackage

// File: rtl/mii_coltest_timer.sv
module mii_coltest_timer #(
  parameter int unsigned RISE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_test,
  input  logic tx_en,
  input  logic bit_tick,
  output logic test_on
);
  import mii_crs_col_pkg::*;

  localparam int CW = $clog2(RISE_TICKS + 1);

  logic [CW-1:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !col_test) begin
      rise_cnt <= '0;
      test_on  <= 1'b0;
    end else if (tx_en) begin
      if (bit_tick && !test_on) begin
        if (span_done(int'(rise_cnt), RISE_TICKS)) test_on <= 1'b1;
        else rise_cnt <= rise_cnt + 1'b1;
      end
    end else begin
      rise_cnt <= '0;
      if (bit_tick) test_on <= 1'b0;
    end
  end

  // R5: a tick with transmit low always clears the test collision
  a_r5_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (col_test && !tx_en && bit_tick) |=> !test_on);

  // R4: once raised, the test collision holds while transmit stays high
  a_r4_hold_while_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (col_test && tx_en && test_on) |=> test_on);

endmodule

// File: rtl/mii_heartbeat_gen.sv
module mii_heartbeat_gen #(
  parameter int unsigned DELAY_TICKS = 20,
  parameter int unsigned WIDTH_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic speed_10,
  input  logic hb_disable,
  input  logic bit_tick,
  output logic hb_pulse,
  output logic hb_busy
);
  import mii_crs_col_pkg::*;

  localparam int unsigned MAXT = (DELAY_TICKS > WIDTH_TICKS) ? DELAY_TICKS : WIDTH_TICKS;
  localparam int CW = $clog2(MAXT + 1);

  hb_state_t     state;
  logic [CW-1:0] cnt;
  logic          tx_d;
  logic          tx_fall;

  assign tx_fall  = tx_d && !tx_en;
  assign hb_pulse = (state == HB_PULSE);
  assign hb_busy  = (state != HB_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_d  <= 1'b0;
      state <= HB_IDLE;
      cnt   <= '0;
    end else begin
      tx_d <= tx_en;
      if (tx_en || hb_disable) begin
        state <= HB_IDLE;
        cnt   <= '0;
      end else if (tx_fall) begin
        state <= speed_10 ? HB_WAIT : HB_IDLE;
        cnt   <= '0;
      end else if (bit_tick) begin
        case (state)
          HB_WAIT: begin
            if (span_done(int'(cnt), DELAY_TICKS)) begin
              state <= HB_PULSE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          HB_PULSE: begin
            if (span_done(int'(cnt), WIDTH_TICKS)) begin
              state <= HB_IDLE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  // R8: transmit activity drops any heartbeat by the next cycle
  a_r8_cancel_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> !hb_busy);

  // R7: the disable control leaves nothing pending
  a_r7_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hb_disable |=> !hb_busy);

  // R6: the pulse starts only from the waiting phase on a tick
  a_r6_pulse_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_pulse) |-> ($past(state) == HB_WAIT) && $past(bit_tick));

endmodule

// File: rtl/mii_crs_col_gen.sv
module mii_crs_col_gen #(
  parameter int unsigned TEST_RISE_TICKS = 2,
  parameter int unsigned HB_DELAY_TICKS  = 20,
  parameter int unsigned HB_WIDTH_TICKS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_crs,
  input  logic full_duplex,
  input  logic repeater,
  input  logic speed_10,
  input  logic col_test,
  input  logic hb_disable,
  input  logic bit_tick,
  output logic crs,
  output logic col
);

  logic test_on;
  logic hb_pulse;
  logic hb_busy;
  logic overlap;
  logic tx_counts;

  mii_coltest_timer #(.RISE_TICKS(TEST_RISE_TICKS)) u_test (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_test (col_test),
    .tx_en    (tx_en),
    .bit_tick (bit_tick),
    .test_on  (test_on)
  );

  mii_heartbeat_gen #(.DELAY_TICKS(HB_DELAY_TICKS), .WIDTH_TICKS(HB_WIDTH_TICKS)) u_hb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .speed_10   (speed_10),
    .hb_disable (hb_disable),
    .bit_tick   (bit_tick),
    .hb_pulse   (hb_pulse),
    .hb_busy    (hb_busy)
  );

  assign tx_counts = tx_en && !full_duplex && !repeater;
  assign overlap   = tx_en && rx_crs;
  assign crs       = rx_crs || tx_counts;
  assign col       = !full_duplex && (overlap || test_on || hb_pulse);

  // R3: no collision in full duplex
  a_r3_fd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> !col);

  // R2: half-duplex overlap always shows as collision
  a_r2_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && tx_en && rx_crs) |-> col);

  // R1: received carrier always reaches carrier sense
  a_r1_rx_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crs |-> crs);

  // R9: at the fast speed a heartbeat never begins
  a_r9_no_fast_hb: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_10 && !hb_busy) |=> !hb_busy);

endmodule

// File: tb/mii_crs_col_gen_test.sv
module mii_crs_col_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, rx_crs = 0, full_duplex = 0, repeater = 0;
  logic speed_10 = 0, col_test = 0, hb_disable = 0, bit_tick = 0;
  logic crs, col;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mii_crs_col_gen uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_crs(rx_crs),
    .full_duplex(full_duplex), .repeater(repeater), .speed_10(speed_10),
    .col_test(col_test), .hb_disable(hb_disable), .bit_tick(bit_tick),
    .crs(crs), .col(col)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock edge without tick, sampled on the following falling edge
  task automatic idle_clk();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    bit_tick = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 crs in reset", crs, 1'b0);
    chk("R10 col in reset", col, 1'b0);
    rst_n = 1'b1;
    idle_clk();
    chk("R10 crs after reset", crs, 1'b0);
    chk("R10 col after reset", col, 1'b0);

    // R1 R2 R3: exhaustive sweep, timed features off
    hb_disable = 1'b1;
    for (int v = 0; v < 16; v++) begin
      tx_en = v[0]; rx_crs = v[1]; full_duplex = v[2]; repeater = v[3];
      idle_clk();
      chk("R1 crs sweep", crs, v[1] | (v[0] & ~v[2] & ~v[3]));
      chk(v[2] ? "R3 col fd sweep" : "R2 col sweep", col, v[0] & v[1] & ~v[2]);
    end
    tx_en = 0; rx_crs = 0; full_duplex = 0; repeater = 0;
    idle_clk();

    // R4 R5: collision self-test
    col_test = 1'b1;
    idle_clk();
    tx_en = 1'b1;
    idle_clk();
    chk("R4 no col before ticks", col, 1'b0);
    tick();
    chk("R4 col after 1st tick", col, 1'b0);
    tick();
    chk("R4 col after 2nd tick", col, 1'b1);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R4 col held", col, 1'b1);
    end
    tx_en = 1'b0;
    idle_clk(); idle_clk();
    chk("R5 col until tick", col, 1'b1);
    tick();
    chk("R5 col cleared by tick", col, 1'b0);
    col_test = 1'b0;
    idle_clk();

    // R6: heartbeat window, checked after every tick
    hb_disable = 1'b0; speed_10 = 1'b1;
    tx_en = 1'b1; idle_clk(); idle_clk();
    tx_en = 1'b0; idle_clk();
    for (int k = 1; k <= 34; k++) begin
      tick();
      chk("R6 heartbeat window", col, (k >= 20 && k <= 29));
    end

    // R8: new frame cancels a pending heartbeat
    tx_en = 1'b1; idle_clk();
    tx_en = 1'b0; idle_clk();
    for (int k = 0; k < 5; k++) tick();
    tx_en = 1'b1; idle_clk();
    for (int k = 1; k <= 30; k++) begin
      tick();
      chk("R8 cancelled heartbeat", col, 1'b0);
    end
    // R8: cancel during the pulse
    tx_en = 1'b0; idle_clk();
    for (int k = 0; k < 22; k++) tick();
    chk("R8 pulse running", col, 1'b1);
    tx_en = 1'b1; idle_clk();
    tx_en = 1'b0;
    chk("R8 pulse dropped", col, 1'b0);
    idle_clk();
    // a fresh heartbeat was armed by that fall; let it run out
    for (int k = 0; k < 32; k++) tick();

    // R7: disabled heartbeat
    hb_disable = 1'b1;
    tx_en = 1'b1; idle_clk();
    tx_en = 1'b0; idle_clk();
    for (int k = 1; k <= 34; k++) begin
      tick();
      chk("R7 disabled heartbeat", col, 1'b0);
    end
    // R7: disable raised while pending drops it
    hb_disable = 1'b0;
    tx_en = 1'b1; idle_clk();
    tx_en = 1'b0; idle_clk();
    for (int k = 0; k < 10; k++) tick();
    hb_disable = 1'b1; idle_clk();
    hb_disable = 1'b0;
    for (int k = 1; k <= 25; k++) begin
      tick();
      chk("R7 pending dropped", col, 1'b0);
    end

    // R9: 100 Mb/s, no heartbeat
    speed_10 = 1'b0;
    tx_en = 1'b1; idle_clk();
    tx_en = 1'b0; idle_clk();
    for (int k = 1; k <= 34; k++) begin
      tick();
      chk("R9 no heartbeat fast", col, 1'b0);
    end

    // R3: heartbeat masked in full duplex
    speed_10 = 1'b1; full_duplex = 1'b1;
    tx_en = 1'b1; idle_clk();
    tx_en = 1'b0; idle_clk();
    for (int k = 1; k <= 34; k++) begin
      tick();
      chk("R3 fd masks heartbeat", col, 1'b0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule